// File: doc/BRIEF.md
# Write-Through Data Cache with Byte Lanes

This block sits between a pipeline's load/store port and a slow backing memory that answers after a variable number of cycles. It is direct-mapped. Each line holds a single data word. The valid bits and tags are kept in one storage array and the data words in another. A load that finds its word in the cache is answered combinationally in the same cycle, without stalling. A load that misses goes to memory, and so does every store. For those accesses the block holds a stall toward the pipeline until memory raises its completion strobe.

Stores always reach memory. A store that hits also updates the cached copy, and a byte store changes only its own lane. A store that misses leaves the cache untouched. Addresses at or above a configurable boundary, `0x4000_0000` by default, belong to devices. Loads and stores in that region always go to memory and never fill a line.

A byte load that misses still fetches the whole aligned word, installs it, and returns the addressed lane.

Top module: `dcache_wt`

## Requirements
- R1: A load to a cacheable address whose line is valid with a matching tag returns its data in the same cycle, with `cpu_stall` low and neither `mem_rd` nor `mem_wr` raised.
- R2: A cacheable load that misses raises `mem_rd` with the word-aligned address (low two bits zero) and `mem_byte` low. It holds `cpu_stall` high until `mem_done` arrives, returns the memory word in the `mem_done` cycle, and installs it so that the next load of that word hits.
- R3: A byte load returns the lane picked by address bits [1:0], zero-extended into `cpu_rdata[7:0]`. Lane k is bits [8k+7:8k] of the word. On a miss, the full containing word is fetched and installed.
- R4: Every store raises `mem_wr` with the unmodified address, `mem_byte` equal to `cpu_byte`, and the store data. For a byte store, `cpu_wdata[7:0]` is repeated in all four lanes of `mem_wdata`. `cpu_stall` stays high until `mem_done`.
- R5: A word store that hits replaces the cached word, and later hits return the new value.
- R6: A byte store that hits changes only the addressed lane of the cached word.
- R7: A store that misses installs nothing: a later load of that word still misses.
- R8: A load at or above `UNCACHED_BASE` always raises `mem_rd`. It never fills a line, so repeated loads of the same device address each go to memory.
- R9: After reset, no line is valid, so the first load to any address misses.
- R10: Two cacheable addresses that share an index but differ in tag evict each other: alternating loads between them all miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all valid bits |
| cpu_rd | input | 1 | Load request |
| cpu_wr | input | 1 | Store request |
| cpu_byte | input | 1 | 1 = byte access, 0 = word access |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store data (byte stores use bits [7:0]) |
| cpu_rdata | output | DATA_W | Load data (byte loads zero-extended) |
| cpu_stall | output | 1 | Hold the pipeline |
| mem_rd | output | 1 | Memory read request (full aligned word) |
| mem_wr | output | 1 | Memory write request |
| mem_byte | output | 1 | Memory write is a single byte |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_done` |
| mem_done | input | 1 | Memory completes the current request this cycle |

## Verification
The checker assumes three things about the pipeline. It never raises load and store together. It keeps a request stable while `cpu_stall` is high. It issues word accesses only on aligned addresses. The checker also assumes that memory raises `mem_done` for one cycle, and only while a request is present.

The bench drives requests through a task that holds each request until the stall drops, and picks only aligned word addresses. Its memory model counts a fixed latency before pulsing the done strobe and clears it at once. The device region returns a value that changes on every read, so any stale cached copy would show up as a hit where a miss is expected.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_LOAD  = 2'd1,
      OP_STORE = 2'd2
   } dc_op_e;

   function automatic dc_op_e decode_op(input logic rd, input logic wr);
      if (wr)      return OP_STORE;
      else if (rd) return OP_LOAD;
      else         return OP_IDLE;
   endfunction

endpackage

// File: rtl/dcache_tag_array.sv
module dcache_tag_array #(
   parameter int IDX_W = 4,
   parameter int TAG_W = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   output logic [TAG_W-1:0] rd_tag,
   output logic             rd_valid,
   input  logic             wr_en,
   input  logic [TAG_W-1:0] wr_tag
);
   localparam int LINES = 1 << IDX_W;

   logic [LINES-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= '0;
      else if (wr_en) valid_q[idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) tag_q[idx] <= wr_tag;
   end

   assign rd_valid = valid_q[idx];
   assign rd_tag   = tag_q[idx];
endmodule

// File: rtl/dcache_data_array.sv
module dcache_data_array #(
   parameter int IDX_W  = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W/8-1:0] lane_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int LINES = 1 << IDX_W;
   localparam int LANES = DATA_W / 8;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [7:0] store_q [LINES];
      always_ff @(posedge clk) begin
         if (lane_we[k]) store_q[idx] <= wdata[k*8 +: 8];
      end
      assign rdata[k*8 +: 8] = store_q[idx];
   end
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
   import dcache_pkg::*;
(
   input  logic cpu_rd,
   input  logic cpu_wr,
   input  logic cacheable,
   input  logic line_valid,
   input  logic tag_equal,
   input  logic mem_done,
   output logic mem_rd,
   output logic mem_wr,
   output logic stall,
   output logic fill_en,
   output logic store_hit_en
);
   dc_op_e op;
   logic   hit;

   always_comb begin
      op           = decode_op(cpu_rd, cpu_wr);
      hit          = cacheable && line_valid && tag_equal;
      mem_rd       = (op == OP_LOAD) && !hit;
      mem_wr       = (op == OP_STORE);
      stall        = (mem_rd || mem_wr) && !mem_done;
      fill_en      = mem_rd && mem_done && cacheable;
      store_hit_en = mem_wr && mem_done && hit;
   end
endmodule

// File: rtl/dcache_wt.sv
module dcache_wt #(
   parameter int              ADDR_W        = 32,
   parameter int              DATA_W        = 32,
   parameter int              IDX_W         = 4,
   parameter logic [ADDR_W-1:0] UNCACHED_BASE = 32'h4000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic              cpu_byte,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_stall,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              mem_byte,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_done
);
   localparam int LANES = DATA_W / 8;
   localparam int OFF_W = $clog2(LANES);
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

   if (DATA_W % 8 != 0 || LANES < 2 || (1 << OFF_W) != LANES)
      $error("dcache_wt: DATA_W must be a power-of-two number of bytes");
   if (IDX_W < 1 || TAG_W < 1)
      $error("dcache_wt: IDX_W leaves no room for index or tag");

   logic [IDX_W-1:0]  idx;
   logic [TAG_W-1:0]  req_tag, line_tag;
   logic [OFF_W-1:0]  lane_sel;
   logic              line_valid, cacheable;
   logic              fill_en, store_hit_en;
   logic [LANES-1:0]  lane_en, data_we;
   logic [DATA_W-1:0] store_word, array_wdata, cached_word, src_word;
   logic [7:0]        lane_bytes [LANES];

   assign idx       = cpu_addr[OFF_W +: IDX_W];
   assign req_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
   assign lane_sel  = cpu_addr[OFF_W-1:0];
   assign cacheable = (cpu_addr < UNCACHED_BASE);

   for (genvar k = 0; k < LANES; k++) begin : g_lanes
      assign lane_en[k] = !cpu_byte || (lane_sel == OFF_W'(k));
      assign store_word[k*8 +: 8] = cpu_byte ? cpu_wdata[7:0] : cpu_wdata[k*8 +: 8];
      assign lane_bytes[k] = src_word[k*8 +: 8];
   end

   dcache_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx      (idx),
      .rd_tag   (line_tag),
      .rd_valid (line_valid),
      .wr_en    (fill_en),
      .wr_tag   (req_tag)
   );

   always_comb begin
      if (fill_en) begin
         data_we     = '1;
         array_wdata = mem_rdata;
      end else if (store_hit_en) begin
         data_we     = lane_en;
         array_wdata = store_word;
      end else begin
         data_we     = '0;
         array_wdata = store_word;
      end
   end

   dcache_data_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
      .clk     (clk),
      .idx     (idx),
      .lane_we (data_we),
      .wdata   (array_wdata),
      .rdata   (cached_word)
   );

   dcache_ctrl u_ctrl (
      .cpu_rd       (cpu_rd),
      .cpu_wr       (cpu_wr),
      .cacheable    (cacheable),
      .line_valid   (line_valid),
      .tag_equal    (line_tag == req_tag),
      .mem_done     (mem_done),
      .mem_rd       (mem_rd),
      .mem_wr       (mem_wr),
      .stall        (cpu_stall),
      .fill_en      (fill_en),
      .store_hit_en (store_hit_en)
   );

   assign src_word  = mem_rd ? mem_rdata : cached_word;
   assign cpu_rdata = cpu_byte ? {{(DATA_W-8){1'b0}}, lane_bytes[lane_sel]} : src_word;

   assign mem_byte  = mem_wr && cpu_byte;
   assign mem_addr  = mem_wr ? cpu_addr : {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign mem_wdata = store_word;
endmodule

// File: rtl/dcache_wt_chk.sv
module dcache_wt_chk #(
   parameter int              ADDR_W        = 32,
   parameter int              DATA_W        = 32,
   parameter logic [ADDR_W-1:0] UNCACHED_BASE = 32'h4000_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_rd,
   input logic              cpu_wr,
   input logic              cpu_byte,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_stall,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              mem_byte,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_done
);
   localparam int OFF_W = $clog2(DATA_W / 8);

   logic any_fill_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) any_fill_q <= 1'b0;
      else if (mem_rd && mem_done && cpu_addr < UNCACHED_BASE) any_fill_q <= 1'b1;
   end

   // R1
   idle_mem_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_rd && !mem_wr) |-> !cpu_stall);
   // R2
   fetch_aligned_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> (mem_addr[OFF_W-1:0] == '0 && !mem_byte));
   // R2
   wait_holds_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && mem_rd && !mem_done) |-> cpu_stall);
   // R4
   store_forwarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wr |-> (mem_wr && mem_addr == cpu_addr && mem_byte == cpu_byte));
   // R4
   store_waits_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && !mem_done) |-> cpu_stall);
   // R7
   store_never_fetches_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wr |-> !mem_rd);
   // R8
   device_load_to_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && cpu_addr >= UNCACHED_BASE) |-> mem_rd);
   // R9
   cold_load_misses_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && !any_fill_q) |-> mem_rd);
endmodule

bind dcache_wt dcache_wt_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNCACHED_BASE(UNCACHED_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
   .cpu_byte(cpu_byte), .cpu_addr(cpu_addr), .cpu_stall(cpu_stall),
   .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_byte(mem_byte),
   .mem_addr(mem_addr), .mem_done(mem_done)
);

// File: tb/tb_dcache_wt.sv
module tb_dcache_wt;
   localparam int          IDX_W = 4;
   localparam int          LAT   = 3;
   localparam logic [31:0] BASE  = 32'h4000_0000;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cpu_rd = 0, cpu_wr = 0, cpu_byte = 0;
   logic [31:0] cpu_addr = 0, cpu_wdata = 0, cpu_rdata;
   logic        cpu_stall, mem_rd, mem_wr, mem_byte;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = 0;
   logic        mem_done = 0;

   int compared = 0, mismatched = 0, cycles = 0, cnt = 0;
   int unsigned dev_count = 0;
   logic [31:0] backing [int unsigned];
   bit          mval [int];
   logic [31:0] mtag [int];

   always #10 clk = ~clk;

   dcache_wt #(.IDX_W(IDX_W), .UNCACHED_BASE(BASE)) dut (
      .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .cpu_byte(cpu_byte), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_byte(mem_byte), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done)
   );

   function automatic logic [31:0] word_at(input logic [31:0] a);
      logic [31:0] w = {a[31:2], 2'b00};
      if (w >= BASE) return 32'hD000_0000 + dev_count;
      if (backing.exists(w)) return backing[w];
      return (w * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
   endfunction

   // memory model: fixed latency, one-cycle done pulse
   always @(posedge clk) begin
      if (mem_done) begin
         mem_done <= 0;
         cnt = 0;
         if (mem_wr && mem_addr < BASE) begin
            logic [31:0] w = word_at(mem_addr);
            if (mem_byte) w[mem_addr[1:0]*8 +: 8] = mem_wdata[mem_addr[1:0]*8 +: 8];
            else          w = mem_wdata;
            backing[{mem_addr[31:2], 2'b00}] = w;
         end
         if (mem_rd && mem_addr >= BASE) dev_count++;
      end else if (rst_n && (mem_rd || mem_wr)) begin
         if (cnt == LAT - 1) begin
            mem_done  <= 1;
            mem_rdata <= word_at(mem_addr);
         end else cnt++;
      end else cnt = 0;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic op(input bit rd, input bit wr, input bit byt,
                     input logic [31:0] a, input logic [31:0] d, input string req);
      int  idx = int'(a[IDX_W+1:2]);
      logic [31:0] tg = a >> (IDX_W + 2);
      bit  cach = a < BASE;
      bit  hit = cach && mval.exists(idx) && mval[idx] && mtag[idx] == tg;
      bit  need = wr || (rd && !hit);
      int  waited = 0;
      logic [31:0] w, exp;
      cpu_rd = rd; cpu_wr = wr; cpu_byte = byt; cpu_addr = a; cpu_wdata = d;
      forever begin
         #1;
         chk(cpu_stall == (need && !mem_done), req, "stall", 32'(cpu_stall), 32'(need && !mem_done));
         chk(mem_rd == (rd && need) && mem_wr == wr, req, "mem request",
             {30'd0, mem_rd, mem_wr}, {30'd0, rd && need, wr});
         if (!(need && !mem_done)) break;
         if (waited > LAT + 2) break;
         @(negedge clk);
         waited++;
      end
      chk(waited == (need ? LAT : 0), req, "wait cycles", 32'(waited), 32'(need ? LAT : 0));
      if (wr) begin
         w = byt ? {4{d[7:0]}} : d;
         chk(mem_addr == a && mem_byte == byt && mem_wdata == w, req, "store forward", mem_wdata, w);
      end
      if (rd) begin
         w = word_at(a);
         exp = byt ? {24'd0, w[a[1:0]*8 +: 8]} : w;
         chk(cpu_rdata == exp, req, "load data", cpu_rdata, exp);
      end
      @(posedge clk);
      if (rd && need && cach) begin mval[idx] = 1; mtag[idx] = tg; end
      @(negedge clk);
      cpu_rd = 0; cpu_wr = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(cpu_stall == 0 && mem_rd == 0 && mem_wr == 0, "R9", "reset idle", 32'(cpu_stall), 0);
      rst_n = 1;
      @(negedge clk);
      op(1,0,0, 32'h100, 0, "R9");
      op(1,0,0, 32'h100, 0, "R1");
      op(1,0,0, 32'h104, 0, "R2");
      op(1,0,0, 32'h104, 0, "R2");
      for (int k = 0; k < 4; k++) op(1,0,1, 32'h100 + k, 0, "R3");
      op(1,0,1, 32'h20B, 0, "R3");
      op(1,0,0, 32'h208, 0, "R3");
      op(0,1,0, 32'h100, 32'hCAFE_F00D, "R4");
      op(1,0,0, 32'h100, 0, "R5");
      op(0,1,1, 32'h101, 32'h0000_0077, "R6");
      op(1,0,0, 32'h100, 0, "R6");
      op(1,0,1, 32'h102, 0, "R6");
      op(0,1,0, 32'h380, 32'h1234_5678, "R7");
      op(1,0,0, 32'h380, 0, "R7");
      op(0,1,1, 32'h3C6, 32'h0000_00AB, "R7");
      op(1,0,1, 32'h3C6, 0, "R7");
      op(1,0,0, 32'h4000_0010, 0, "R8");
      op(1,0,0, 32'h4000_0010, 0, "R8");
      op(0,1,1, 32'h4000_0013, 32'h0000_0055, "R8");
      op(1,0,1, 32'h4000_0011, 0, "R8");
      for (int k = 0; k < 4; k++) begin
         op(1,0,0, 32'h140, 0, "R10");
         op(1,0,0, 32'h540, 0, "R10");
      end
      for (int n = 0; n < 400; n++) begin
         int r = $urandom_range(0, 9);
         logic [31:0] a = (r == 9) ? 32'h4000_0020 : 32'h100 + ($urandom_range(0, 23) << 2)
                          + ($urandom_range(0, 1) << 10);
         bit byt = $urandom_range(0, 1);
         if (byt) a[1:0] = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 3) == 0) op(0,1,byt, a, $urandom, "R6");
         else                           op(1,0,byt, a, 0, "R1");
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         compared++;
         mismatched++;
         $display("FAIL R2 watchdog: actual hung expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule